// File: doc/BRIEF.md
# Contact Bounce Pattern Generator

This block shapes the connect-enable of one timing source so that every signal mapped to that source sees an intermittent contact before it settles. The sequencer pulses a start strobe when the source's connect delay runs out on power-up. From the next cycle the generator runs a finite burst: the output alternates between connected and disconnected with a programmed period and duty cycle for a programmed number of ticks. After the burst the output stays connected. A zero burst length gives a clean connection at the source delay.

A disconnect request pulls the output low at once, whatever the generator is doing, and clears the burst. The output stays low until the next start strobe. Length and period are counted in ticks, each tick being `TICK_DIV` clock cycles. The duty cycle is a percentage. With the default of one cycle per tick, a typical setting of 10 ms length, 500 us period and 50 % duty scales to counts in the same ratio.

Top module: `bounce_gen`

## Requirements
- R1: After reset the output `conn_o` is low (disconnected) and stays low while no start strobe arrives.
- R2: A start strobe with a nonzero length L begins a burst on the cycle after the strobe. The burst lasts exactly L ticks.
- R3: During the burst, tick j of the burst (j = 0 first) is connected exactly when (j mod P) < floor(P*D/100). P is the effective period and D the duty. Each period therefore opens in the connected phase.
- R4: Once the burst ends, `conn_o` stays high until a disconnect request.
- R5: A start strobe with length 0 makes `conn_o` high from the next cycle on, with no toggling.
- R6: A duty of 0 holds the output low for the whole burst. A duty of 100 or more holds it high for the whole burst.
- R7: A disconnect request drives `conn_o` low from the next cycle, aborts any burst and keeps the output low until a later start strobe. When disconnect and start arrive in the same cycle, the disconnect wins.
- R8: Length, period and duty are captured at the start strobe. Changing them during a burst has no effect on that burst.
- R9: A start strobe during a burst or the settled state restarts the burst from tick 0 with the new settings.
- R10: A programmed period of 0 is treated as a period of 1 tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | One-cycle strobe: the source connect delay has expired |
| disc_i | input | 1 | Disconnect request |
| len_i | input | LEN_W | Burst length in ticks |
| period_i | input | PER_W | Bounce period in ticks |
| duty_i | input | DUTY_W | Connected share of each period, in percent |
| conn_o | output | 1 | Connect-enable shared by all signals of the source |

## Verification
The embedded assertions check several rules on every cycle:
- the output falls after any disconnect request;
- a zero-length start connects at once;
- the settled state holds;
- the idle state stays low without a start;
- the burst and phase counters stay inside their captured limits.

Other behaviour can only be shown by the bench, which compares the full waveform tick by tick against a model of the phase rule:
- the exact burst length;
- the placement of the connected phase;
- the rounding of the duty;
- the clamping of period and duty;
- the capture of settings at the strobe;
- restarts in mid-burst.

// File: rtl/bounce_pkg.sv
package bounce_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_BURST = 2'd1,
    ST_CONN  = 2'd2
  } bstate_e;
endpackage

// File: rtl/bounce_tick.sv
module bounce_tick #(
  parameter int TICK_DIV = 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  output logic tick_o
);
  localparam int CW = $clog2(TICK_DIV + 1);
  localparam logic [CW-1:0] LAST = CW'(TICK_DIV - 1);

  logic [CW-1:0] cnt_q;

  assign tick_o = (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          cnt_q <= '0;
    else if (clr_i)       cnt_q <= '0;
    else if (tick_o)      cnt_q <= '0;
    else                  cnt_q <= cnt_q + 1'b1;
  end

  a_r2_tick_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LAST);
endmodule

// File: rtl/bounce_duty.sv
module bounce_duty #(
  parameter int PER_W  = 16,
  parameter int DUTY_W = 7
) (
  input  logic [PER_W-1:0]  period_i,
  input  logic [DUTY_W-1:0] duty_i,
  output logic [PER_W-1:0]  per_eff_o,
  output logic [PER_W-1:0]  on_o
);
  localparam int PW = PER_W + DUTY_W;
  localparam logic [DUTY_W-1:0] FULL = DUTY_W'(100);

  logic [DUTY_W-1:0] duty_c;
  logic [PW-1:0]     prod;

  always_comb begin
    per_eff_o = (period_i == '0) ? PER_W'(1) : period_i;   // R10
    duty_c    = (duty_i > FULL) ? FULL : duty_i;           // R6 clamp
    prod      = PW'(per_eff_o) * PW'(duty_c);
    on_o      = PER_W'(prod / PW'(100));
  end

  always_comb begin
    a_r3_on_within_period: assert (on_o <= per_eff_o);
  end
endmodule

// File: rtl/bounce_burst.sv
module bounce_burst
  import bounce_pkg::*;
#(
  parameter int LEN_W = 24,
  parameter int PER_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             disc_i,
  input  logic             tick_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic [PER_W-1:0] per_i,
  input  logic [PER_W-1:0] on_i,
  output logic             conn_o,
  output logic             in_burst_o
);
  bstate_e          state_q;
  logic [LEN_W-1:0] len_q, len_cnt_q;
  logic [PER_W-1:0] per_q, on_q, ph_cnt_q;
  logic             last_tick, last_ph;

  assign last_tick = (len_cnt_q == len_q - 1'b1);
  assign last_ph   = (ph_cnt_q == per_q - 1'b1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      len_q     <= '0;
      per_q     <= PER_W'(1);
      on_q      <= '0;
      len_cnt_q <= '0;
      ph_cnt_q  <= '0;
    end else if (disc_i) begin
      state_q   <= ST_IDLE;
      len_cnt_q <= '0;
      ph_cnt_q  <= '0;
    end else if (start_i) begin
      // settings captured here only (R8), restart from tick 0 (R9)
      len_q     <= len_i;
      per_q     <= per_i;
      on_q      <= on_i;
      len_cnt_q <= '0;
      ph_cnt_q  <= '0;
      state_q   <= (len_i == '0) ? ST_CONN : ST_BURST;
    end else if (state_q == ST_BURST && tick_i) begin
      if (last_tick) begin
        state_q   <= ST_CONN;
        len_cnt_q <= '0;
        ph_cnt_q  <= '0;
      end else begin
        len_cnt_q <= len_cnt_q + 1'b1;
        ph_cnt_q  <= last_ph ? '0 : ph_cnt_q + 1'b1;
      end
    end
  end

  always_comb begin
    in_burst_o = (state_q == ST_BURST);
    conn_o     = (state_q == ST_CONN) || (in_burst_o && (ph_cnt_q < on_q));
  end

  a_r7_disc_forces_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    disc_i |=> !conn_o && !in_burst_o);

  a_r7_idle_holds_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!conn_o && !in_burst_o && !start_i) |=> !conn_o);

  a_r5_zero_len_connects: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !disc_i && len_i == '0) |=> (conn_o && !in_burst_o));

  a_r3_period_opens_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !disc_i && len_i != '0 && on_i != '0) |=> (conn_o && in_burst_o));

  a_r4_settled_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (conn_o && !in_burst_o && !disc_i && !start_i) |=> (conn_o && !in_burst_o));

  a_r2_len_cnt_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_burst_o |-> (len_cnt_q < len_q));

  a_r3_phase_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_burst_o |-> (ph_cnt_q < per_q));
endmodule

// File: rtl/bounce_gen.sv
module bounce_gen #(
  parameter int LEN_W    = 24,
  parameter int PER_W    = 16,
  parameter int DUTY_W   = 7,
  parameter int TICK_DIV = 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              disc_i,
  input  logic [LEN_W-1:0]  len_i,
  input  logic [PER_W-1:0]  period_i,
  input  logic [DUTY_W-1:0] duty_i,
  output logic              conn_o
);
  logic             tick;
  logic             in_burst;
  logic [PER_W-1:0] per_eff, on_ticks;

  bounce_tick #(.TICK_DIV(TICK_DIV)) u_tick (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (start_i | disc_i),
    .tick_o (tick)
  );

  bounce_duty #(.PER_W(PER_W), .DUTY_W(DUTY_W)) u_duty (
    .period_i  (period_i),
    .duty_i    (duty_i),
    .per_eff_o (per_eff),
    .on_o      (on_ticks)
  );

  bounce_burst #(.LEN_W(LEN_W), .PER_W(PER_W)) u_burst (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start_i),
    .disc_i     (disc_i),
    .tick_i     (tick),
    .len_i      (len_i),
    .per_i      (per_eff),
    .on_i       (on_ticks),
    .conn_o     (conn_o),
    .in_burst_o (in_burst)
  );

  a_r1_no_burst_without_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!in_burst && !start_i) |=> !in_burst);
endmodule

// File: tb/bounce_gen_test.sv
module bounce_gen_test;
  localparam int LEN_W = 24, PER_W = 16, DUTY_W = 7;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0, disc = 1'b0;
  logic [LEN_W-1:0]  len = '0;
  logic [PER_W-1:0]  per = '0;
  logic [DUTY_W-1:0] duty = '0;
  logic conn;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  bounce_gen #(.LEN_W(LEN_W), .PER_W(PER_W), .DUTY_W(DUTY_W)) uut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .disc_i(disc),
    .len_i(len), .period_i(per), .duty_i(duty), .conn_o(conn)
  );

  task automatic chk(input logic act, input logic exp, input string req);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s at %0t: conn actual %b expected %b", req, $time, act, exp);
    end
  endtask

  function automatic logic model(int j, int l, int p, int d);
    int pe, de, on;
    if (j >= l) return 1'b1;
    pe = (p == 0) ? 1 : p;
    de = (d > 100) ? 100 : d;
    on = (pe * de) / 100;
    return ((j % pe) < on);
  endfunction

  // strobe; returns at the negedge where burst tick 0 is visible
  task automatic do_start(input int l, input int p, input int d);
    @(negedge clk);
    len = LEN_W'(l); per = PER_W'(p); duty = DUTY_W'(d);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic run_check(input int l, input int p, input int d, input int n, input string req);
    for (int j = 0; j < n; j++) begin
      chk(conn, model(j, l, p, d), req);
      @(negedge clk);
    end
  endtask

  task automatic go_idle();
    @(negedge clk); disc = 1'b1;
    @(negedge clk); disc = 1'b0;
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(conn, 1'b0, "R1");
    for (int k = 0; k < 10; k++) begin @(negedge clk); chk(conn, 1'b0, "R1"); end
  endtask

  task automatic t_typical();
    do_start(40, 10, 50); run_check(40, 10, 50, 60, "R2/R3/R4");
    go_idle();
  endtask

  task automatic t_round();
    do_start(13, 5, 60); run_check(13, 5, 60, 20, "R3");
    go_idle();
    do_start(21, 7, 30); run_check(21, 7, 30, 30, "R3");
    go_idle();
  endtask

  task automatic t_duty_edges();
    do_start(15, 4, 0);   run_check(15, 4, 0, 22, "R6");
    go_idle();
    do_start(15, 4, 100); run_check(15, 4, 100, 22, "R6");
    go_idle();
    do_start(15, 4, 127); run_check(15, 4, 127, 22, "R6");
    go_idle();
  endtask

  task automatic t_zero_len();
    do_start(0, 6, 50); run_check(0, 6, 50, 12, "R5");
    go_idle();
  endtask

  task automatic t_zero_period();
    do_start(8, 0, 100); run_check(8, 0, 100, 12, "R10");
    go_idle();
    do_start(8, 0, 50);  run_check(8, 0, 50, 12, "R10");
    go_idle();
  endtask

  task automatic t_disc();
    do_start(50, 10, 50); run_check(50, 10, 50, 5, "R7");
    disc = 1'b1; @(negedge clk); disc = 1'b0;
    for (int k = 0; k < 20; k++) begin chk(conn, 1'b0, "R7"); @(negedge clk); end
    // settled then disconnect
    do_start(0, 4, 50); chk(conn, 1'b1, "R5");
    disc = 1'b1; @(negedge clk); disc = 1'b0;
    chk(conn, 1'b0, "R7");
    // same-cycle start and disconnect
    len = 24'd0; start = 1'b1; disc = 1'b1;
    @(negedge clk); start = 1'b0; disc = 1'b0;
    for (int k = 0; k < 5; k++) begin chk(conn, 1'b0, "R7"); @(negedge clk); end
  endtask

  task automatic t_capture();
    do_start(20, 4, 50);
    len = 24'd3; per = 16'd9; duty = 7'd0;
    run_check(20, 4, 50, 26, "R8");
    go_idle();
  endtask

  task automatic t_restart();
    do_start(30, 6, 50); run_check(30, 6, 50, 8, "R9");
    do_start(12, 4, 75); run_check(12, 4, 75, 16, "R9");
    do_start(9, 3, 34);  run_check(9, 3, 34, 12, "R9");
    go_idle();
  endtask

  task automatic t_hold();
    do_start(6, 2, 50); run_check(6, 2, 50, 6, "R2");
    for (int k = 0; k < 50; k++) begin chk(conn, 1'b1, "R4"); @(negedge clk); end
    go_idle();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_typical();
    t_round();
    t_duty_edges();
    t_zero_len();
    t_zero_period();
    t_disc();
    t_capture();
    t_restart();
    t_hold();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule